// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point words in the single-precision interchange layout. The sign is the top bit, the 8-bit exponent is biased by 127 and sits above the 23-bit fraction, and every nonzero operand carries an implied leading 1. Operands are limited to normal numbers and zero. Any word whose exponent field is 0 is read as zero.

The unit is a three-stage pipeline and accepts a new operation every cycle. The first stage restores hidden bits, flips the sign of the second operand for a subtraction, and orders the operands by magnitude. The second stage aligns the smaller significand with three extra low bits (guard, round and sticky) and then adds or subtracts. The third stage normalizes, rounds to nearest with ties to even, renormalizes, and either packs the result or clamps it. An operation presented with `inValid` produces `outValid` and `result` three clock edges later.

Top module: `fpAdder`

## Requirements
- R1: For normal or zero operands, with `subSel`=0, `result` is the sum of `opA` and `opB` rounded to nearest, ties to even, in the same 32-bit layout (bit 31 sign, bits 30:23 biased exponent, bits 22:0 fraction).
- R2: With `subSel`=1 the result equals `opA` plus `opB` with bit 31 of `opB` inverted.
- R3: When the exact result is zero (equal magnitudes with opposite effective signs, or both operands zero), `result` is +0 (32'h00000000).
- R4: Bits of the smaller significand shifted past the round position are ORed into a sticky bit, so a discarded part that exceeds half an ulp rounds up even when the exponent gap exceeds 24.
- R5: A discarded part of exactly half an ulp rounds to the neighbour whose fraction LSB is 0.
- R6: When rounding carries out of the significand, the exponent is incremented and the fraction becomes zero.
- R7: A difference that cancels several leading bits is shifted left until its leading 1 reaches the hidden position, and the exponent drops by the shift count.
- R8: A result whose exponent would reach 255 becomes the largest finite value of the result's sign ({sign, 8'hFE, 23'h7FFFFF}). No output has exponent field 255.
- R9: A result whose exponent would be 0 or below is flushed to a zero carrying the result's sign. No output has exponent 0 with a nonzero fraction.
- R10: An operand whose exponent field is 0 counts as zero whatever its fraction bits, so the other operand (sign-adjusted per R2) passes through unchanged.
- R11: `outValid` is high exactly three cycles after `inValid` was sampled high, and back-to-back operations come out in order, one per cycle.
- R12: While `rstN` is low, `outValid` and `result` are 0.
- R13: `result` keeps its value in every cycle where `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation present on opA/opB/subSel this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| subSel | input | 1 | 1 selects opA minus opB |
| outValid | output | 1 | result holds a new value this cycle |
| result | output | 32 | Rounded sum or difference |

## Verification
Each result is due on the third rising edge after the edge that samples `inValid`. Inputs are driven on the falling edge before that sampling edge. The bench then waits three falling edges and reads `outValid` and `result` there, and one falling edge earlier it confirms that `outValid` is still low. In the burst test, three operations are issued on consecutive cycles and their results are read on three consecutive falling edges starting at that same offset. The hold check reads `result` again two cycles after it appears.

// File: rtl/fpAddPkg.sv
`timescale 1ns/1ps
package fpAddPkg;
  localparam int ExpW   = 8;
  localparam int FracW  = 23;
  localparam int WordW  = 1 + ExpW + FracW;
  localparam int MagW   = WordW - 1;
  localparam int SigW   = FracW + 1;
  localparam int ExtW   = SigW + 3;
  localparam int SumW   = ExtW + 1;
  localparam int WideW  = SigW + ExtW;
  localparam int LzW    = $clog2(ExtW + 1);
  localparam int ExpSW  = ExpW + 2;
  localparam int ShMax  = ExtW;
  localparam logic [ExpW-1:0] ExpTop = '1;

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } strobeT;

  function automatic logic [LzW-1:0] leadZeros(input logic [ExtW-1:0] v);
    logic [LzW-1:0] n;
    n = '0;
    for (int i = 0; i < ExtW; i++) begin
      if (v[i]) n = LzW'(ExtW - 1 - i);
    end
    return n;
  endfunction
endpackage

// File: rtl/fpAddCtrl.sv
`timescale 1ns/1ps
module fpAddCtrl
  import fpAddPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  output strobeT stb,
  output logic   outValid
);
  localparam int Stages = 3;
  logic [Stages-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[Stages-2:0], inValid};
  end

  assign stb.ld1  = inValid;
  assign stb.ld2  = vPipe[0];
  assign stb.ld3  = vPipe[1];
  assign outValid = vPipe[Stages-1];
endmodule

// File: rtl/fpAddDatapath.sv
`timescale 1ns/1ps
module fpAddDatapath
  import fpAddPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [WordW-1:0] opA,
  input  logic [WordW-1:0] opB,
  input  logic             subSel,
  output logic [WordW-1:0] result
);
  // ---------------- stage 1: unpack, order by magnitude ----------------
  logic [MagW-1:0] cleanA, cleanB, bigMag, smallMag;
  logic            signA, signB, swapOps;
  logic [SigW-1:0] bigSigC, smallSigC;
  logic [ExpW-1:0] diffC;

  always_comb begin
    signA    = opA[WordW-1];
    signB    = opB[WordW-1] ^ subSel;
    cleanA   = (opA[MagW-1 -: ExpW] == '0) ? '0 : opA[MagW-1:0];
    cleanB   = (opB[MagW-1 -: ExpW] == '0) ? '0 : opB[MagW-1:0];
    swapOps  = cleanB > cleanA;
    bigMag   = swapOps ? cleanB : cleanA;
    smallMag = swapOps ? cleanA : cleanB;
    bigSigC   = {|bigMag[MagW-1 -: ExpW], bigMag[FracW-1:0]};
    smallSigC = {|smallMag[MagW-1 -: ExpW], smallMag[FracW-1:0]};
    diffC    = bigMag[MagW-1 -: ExpW] - smallMag[MagW-1 -: ExpW];
  end

  logic            s1BigSign, s1SmallSign;
  logic [ExpW-1:0] s1Exp, s1Diff;
  logic [SigW-1:0] s1BigSig, s1SmallSig;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1BigSign <= 1'b0; s1SmallSign <= 1'b0;
      s1Exp <= '0; s1Diff <= '0; s1BigSig <= '0; s1SmallSig <= '0;
    end else if (stb.ld1) begin
      s1BigSign   <= swapOps ? signB : signA;
      s1SmallSign <= swapOps ? signA : signB;
      s1Exp       <= bigMag[MagW-1 -: ExpW];
      s1Diff      <= diffC;
      s1BigSig    <= bigSigC;
      s1SmallSig  <= smallSigC;
    end
  end

  // ---------------- stage 2: align with guard/round/sticky, add ----------------
  logic [ExpW-1:0] shAmt;
  logic [WideW-1:0] wide;
  logic [ExtW-1:0] alignedSmall, bigExt;
  logic [SumW-1:0] sumC;

  always_comb begin
    shAmt        = (s1Diff > ExpW'(ShMax)) ? ExpW'(ShMax) : s1Diff;
    wide         = {s1SmallSig, {ExtW{1'b0}}} >> shAmt;
    alignedSmall = {wide[WideW-1 -: ExtW-1], |wide[SigW:0]};
    bigExt       = {s1BigSig, 3'b000};
    if (s1BigSign == s1SmallSign) sumC = {1'b0, bigExt} + {1'b0, alignedSmall};
    else                          sumC = {1'b0, bigExt} - {1'b0, alignedSmall};
  end

  logic            s2Sign;
  logic [ExpW-1:0] s2Exp;
  logic [SumW-1:0] s2Sum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Sign <= 1'b0; s2Exp <= '0; s2Sum <= '0;
    end else if (stb.ld2) begin
      s2Sign <= s1BigSign;
      s2Exp  <= s1Exp;
      s2Sum  <= sumC;
    end
  end

  // ---------------- stage 3: normalize, round, renormalize, pack ----------------
  logic [ExtW-1:0]       normSig;
  logic [LzW-1:0]        lz;
  logic signed [ExpSW-1:0] expN, expF;
  logic [SigW-1:0]       mant;
  logic                  roundUp;
  logic [SigW:0]         mantR;
  logic [FracW-1:0]      fracF;
  logic [WordW-1:0]      packed3;

  always_comb begin
    lz = leadZeros(s2Sum[ExtW-1:0]);
    if (s2Sum[SumW-1]) begin
      normSig = {s2Sum[SumW-1:2], |s2Sum[1:0]};
      expN    = $signed({2'b00, s2Exp}) + ExpSW'(1);
    end else begin
      normSig = s2Sum[ExtW-1:0] << lz;
      expN    = $signed({2'b00, s2Exp}) - $signed({{(ExpSW-LzW){1'b0}}, lz});
    end
    mant    = normSig[ExtW-1:3];
    roundUp = normSig[2] & (normSig[1] | normSig[0] | mant[0]);
    mantR   = {1'b0, mant} + {{SigW{1'b0}}, roundUp};
    if (mantR[SigW]) begin
      expF  = expN + ExpSW'(1);
      fracF = mantR[FracW:1];
    end else begin
      expF  = expN;
      fracF = mantR[FracW-1:0];
    end
    if (s2Sum == '0)
      packed3 = '0;
    else if (expF >= $signed({2'b00, ExpTop}))
      packed3 = {s2Sign, ExpTop - ExpW'(1), {FracW{1'b1}}};
    else if (expF <= 0)
      packed3 = {s2Sign, {MagW{1'b0}}};
    else
      packed3 = {s2Sign, expF[ExpW-1:0], fracF};
  end

  always_ff @(posedge clk) begin
    if (!rstN)        result <= '0;
    else if (stb.ld3) result <= packed3;
  end
endmodule

// File: rtl/fpAdder.sv
`timescale 1ns/1ps
module fpAdder
  import fpAddPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        subSel,
  output logic        outValid,
  output logic [31:0] result
);
  strobeT stb;

  fpAddCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stb(stb), .outValid(outValid)
  );

  fpAddDatapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .opA(opA), .opB(opB), .subSel(subSel), .result(result)
  );
endmodule

// File: rtl/fpAdderChk.sv
`timescale 1ns/1ps
module fpAdderChk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        outValid,
  input logic [31:0] result
);
  logic [1:0] sinceReset;
  always_ff @(posedge clk) begin
    if (!rstN)                 sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  // R11
  latency_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R8
  no_top_exponent_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (result[30:23] != 8'hFF));

  // R9
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && result[30:23] == 8'h00) |-> (result[22:0] == 23'h0));

  // R13
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset != 2'd0 && !outValid) |-> $stable(result));
endmodule

bind fpAdder fpAdderChk uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid), .result(result)
);

// File: tb/tb_fpAdder.sv
`timescale 1ns/1ps
module tb_fpAdder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        subSel = 1'b0;
  logic        outValid;
  logic [31:0] result;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fpAdder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .subSel(subSel), .outValid(outValid), .result(result)
  );

  localparam int NumVec = 17;
  // {opA, opB, subSel, expected}
  localparam logic [96:0] VEC [NumVec] = '{
    {32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000}, // R1 1+1
    {32'h3FC00000, 32'h40200000, 1'b0, 32'h40800000}, // R1 1.5+2.5
    {32'h40400000, 32'h3F800000, 1'b1, 32'h40000000}, // R2 3-1
    {32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000}, // R3 1-1
    {32'h3F800000, 32'hBF400000, 1'b0, 32'h3E800000}, // R7 1-0.75
    {32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000}, // R5 tie, even stays
    {32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002}, // R5 tie, odd rounds up
    {32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001}, // R4 above half
    {32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000}, // R6 carry out
    {32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F7FFFFF}, // R8 saturate
    {32'hBF800000, 32'hC0000000, 1'b0, 32'hC0400000}, // R1 -1 + -2
    {32'h00000000, 32'h40490FDB, 1'b0, 32'h40490FDB}, // R10 zero + x
    {32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000}, // R2 1-(-1)
    {32'h3F800000, 32'h40400000, 1'b0, 32'h40800000}, // R1 swap order
    {32'h00800000, 32'h00C00000, 1'b1, 32'h80000000}, // R9 flush
    {32'h4B800001, 32'h3F800000, 1'b0, 32'h4B800002}, // R5 wide gap tie
    {32'h3F800000, 32'h00800000, 1'b0, 32'h3F800000}  // R4 huge gap sticky
  };

  function automatic string reqOf(int i);
    case (i)
      0, 1, 10, 13: return "R1";
      2, 12:        return "R2";
      3:            return "R3";
      4:            return "R7";
      5, 6, 15:     return "R5";
      7, 16:        return "R4";
      8:            return "R6";
      9:            return "R8";
      11:           return "R10";
      default:      return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic [31:0] exp, input string req);
    @(negedge clk);
    opA = a; opB = b; subSel = s; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check("R11", {31'b0, outValid}, 32'd0);
    @(negedge clk);
    check("R11", {31'b0, outValid}, 32'd1);
    check(req, result, exp);
  endtask

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    check("R12", {31'b0, outValid}, 32'd0);
    check("R12", result, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NumVec; i++) begin
      runOne(VEC[i][96:65], VEC[i][64:33], VEC[i][32], VEC[i][31:0], reqOf(i));
    end

    // R13 result held after outValid drops
    runOne(32'h40000000, 32'h3F800000, 1'b0, 32'h40400000, "R1");
    @(negedge clk);
    @(negedge clk);
    check("R13", {31'b0, outValid}, 32'd0);
    check("R13", result, 32'h40400000);

    // R10 operand with exponent 0 and nonzero fraction counts as zero
    runOne(32'h3F800000, 32'h007FFFFF, 1'b1, 32'h3F800000, "R10");
    // R8 negative saturation
    runOne(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF7FFFFF, "R8");
    // R3 negative equal magnitudes cancel to +0
    runOne(32'hC0A00000, 32'h40A00000, 1'b0, 32'h00000000, "R3");

    // R11 burst of three back-to-back operations
    @(negedge clk);
    opA = 32'h3F800000; opB = 32'h3F800000; subSel = 1'b0; inValid = 1'b1;
    @(negedge clk);
    opA = 32'h40400000; opB = 32'h3F800000; subSel = 1'b1;
    @(negedge clk);
    opA = 32'h40000000; opB = 32'h40000000; subSel = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check("R11", {31'b0, outValid}, 32'd1);
    check("R11", result, 32'h40000000);
    @(negedge clk);
    check("R11", {31'b0, outValid}, 32'd1);
    check("R11", result, 32'h40000000);
    @(negedge clk);
    check("R11", {31'b0, outValid}, 32'd1);
    check("R11", result, 32'h40800000);
    @(negedge clk);
    check("R11", {31'b0, outValid}, 32'd0);

    // R12 reset clears a held result
    rstN = 1'b0;
    @(negedge clk);
    check("R12", result, 32'h0);
    check("R12", {31'b0, outValid}, 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule